// File: doc/BRIEF.md
# Two-Frame Elastic Store with Controlled Slip

This block is a bit-serial buffer that sits between a line-side E1 receive path and a backplane. Bits arrive on a write clock together with a frame marker. They leave on an unrelated read clock, which may be a 1.544 MHz or 2.048 MHz backplane clock or a gapped burst clock of up to 8.192 MHz. The storage holds exactly two frames of 256 bits. The write pointer is passed to the read clock domain as a Gray code through a two-stage synchronizer. All decisions are made in the read domain from the separation between the synchronized write pointer and the read pointer.

Over time the two clocks drift apart. The store then slips in units of a whole frame, and only when the reader is about to start a new frame, so frame alignment on the backplane is never broken. A host in the read clock domain can also recenter the store. The recenter command always places the reader one frame behind the writer. The align command moves the reader to half a frame behind the writer, and only when the reader is already closer than that. One instance serves one direction, so receive and transmit paths each get their own controls.

Top module: `elastic_store_2f`

## Requirements
- R1: Bits written with `w_en` high are read back in write order, one per read cycle with `r_en` high. Storage is 512 bits, organised as two frames of 256 bits.
- R2: Each write stores `w_data` at the next bit position. If `w_fsync` is high with `w_en` and the write position is not at frame offset 0, that bit goes to offset 0 of the next frame slot. Without `w_en`, the write position does not move.
- R3: `r_fsync` is high, for the cycle its bit appears on `r_data`, exactly when that bit came from frame offset 0.
- R4: After reset, `r_data`, `r_fsync`, `slip_evt` and `slip_dir` are 0. The separation starts at one frame: 256 bits between the synchronized write count and the read pointer.
- R5: When a read begins at frame offset 0 with a separation below 256, the previous frame is read again. `slip_evt` pulses for one read cycle with `slip_dir` = 0 (repeat).
- R6: When a read begins at frame offset 0 with a separation above 512, one frame is skipped. `slip_evt` pulses for one read cycle with `slip_dir` = 1 (delete).
- R7: No slip happens on a read away from frame offset 0. Such a read advances the read pointer by exactly one bit.
- R8: `cmd_reset` sets the read pointer to 256 bits behind the synchronized write pointer, whatever the separation. It takes priority over `cmd_align` and over a read in the same cycle, and that cycle reads no bit.
- R9: `cmd_align` (without `cmd_reset`) sets the read pointer to 128 bits behind the synchronized write pointer if the separation is below 128. Otherwise it has no effect. No bit is read in that cycle.
- R10: The write count reaches the read domain through two read-clock register stages. The separation used in read cycle n reflects the write count captured two read edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| w_clk | input | 1 | Line-side write clock |
| w_rst_n | input | 1 | Synchronous active-low reset, write domain |
| w_en | input | 1 | Write strobe, one bit per cycle |
| w_data | input | 1 | Serial data bit to store |
| w_fsync | input | 1 | Marks the current write bit as frame offset 0 |
| r_clk | input | 1 | Backplane read clock |
| r_rst_n | input | 1 | Synchronous active-low reset, read domain |
| r_en | input | 1 | Read strobe, one bit per cycle |
| cmd_reset | input | 1 | Unconditional recenter to one frame |
| cmd_align | input | 1 | Conditional recenter to half a frame |
| r_data | output | 1 | Serial data bit read out |
| r_fsync | output | 1 | High with the bit at frame offset 0 |
| slip_evt | output | 1 | One-cycle pulse on each frame slip |
| slip_dir | output | 1 | 0 = frame repeated, 1 = frame deleted |

## Verification
The hardest state to reach from the ports is an effective align. It needs a separation below 128 bits, and a slip at any frame start pushes the separation straight back up. The stimulus stops the writer, issues `cmd_reset` so the separation is exactly 256, and then reads a varying number of bits before issuing `cmd_align`. Some of these attempts end below 128 within one frame, and others cross a frame start and turn into a repeat. Sustained drift in both directions is produced by running the write clock faster than the read clock for deletes, and by gating `w_en` for repeats.

// File: rtl/es_pkg.sv
// Shared types for the two-frame elastic store.
// Assumes: used by every module of the store; holds no state.
package es_pkg;
    // Kind of frame slip chosen at a read-side frame start.
    typedef enum logic [1:0] {
        SLIP_NONE   = 2'd0,
        SLIP_REPEAT = 2'd1,
        SLIP_DELETE = 2'd2
    } es_slip_e;
endpackage

// File: rtl/es_wr_ptr.sv
// Write-side pointer: advances one bit per write, snaps to the next frame
// start on an off-boundary frame marker, and publishes its value as Gray code.
// Assumes: one write per clock at most; pointer one wrap bit wider than a
// doubled store so separations up to +/- two stores stay unambiguous.
module es_wr_ptr #(
    parameter int FRAME_BITS = 256,
    parameter int AW         = 9,
    parameter int PW         = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          fsync,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] gray
);
    localparam int FW = $clog2(FRAME_BITS);

    logic [PW-1:0] bin;
    logic [PW-1:0] slot;
    logic [PW-1:0] bin_nxt;
    logic          off_edge;

    // Choose the position for this bit, moving to the next frame on a marker.
    always_comb begin
        off_edge = (bin[FW-1:0] != '0);
        slot     = bin;
        if (fsync && off_edge) begin
            slot = {bin[PW-1:FW] + 1'b1, {FW{1'b0}}};
        end
        bin_nxt = slot + 1'b1;
        waddr   = slot[AW-1:0];
        we      = en;
    end

    // Register the binary pointer and its Gray image together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin  <= '0;
            gray <= '0;
        end else if (en) begin
            bin  <= bin_nxt;
            gray <= bin_nxt ^ (bin_nxt >> 1);
        end
    end

    AST_WPTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(bin) && $stable(gray)); // R2
    AST_GRAY_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !(fsync && off_edge)) |=> ($countones(gray ^ $past(gray)) == 1)); // R10
endmodule

// File: rtl/es_gray_sync.sv
// Two-stage synchronizer for a Gray-coded pointer, followed by Gray-to-binary
// conversion in the receiving domain.
// Assumes: the source changes by one Gray step between samples in normal
// running; the reset value of the source is all zeros.
module es_gray_sync #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Capture the foreign Gray value through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    // Convert the settled Gray value back to binary, MSB first.
    always_comb begin
        bin_out[W-1] = stage2[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ stage2[i];
        end
    end

    AST_SYNC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |=> (stage2 == $past(stage1))); // R10
endmodule

// File: rtl/es_bit_ram.sv
// Bit-wide storage for two frames: written on the line clock, read
// combinationally by the read-side controller.
// Assumes: write and read never target the same bit in the same instant
// under correct pointer separation; cleared by the write-domain reset.
module es_bit_ram #(
    parameter int DEPTH = 512,
    parameter int AW    = 9
) (
    input  logic          wclk,
    input  logic          w_rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wdata,
    input  logic [AW-1:0] raddr,
    output logic          rdata
);
    logic [DEPTH-1:0] bits;

    // Store one bit per write strobe; clear the store on reset.
    always_ff @(posedge wclk) begin
        if (!w_rst_n) begin
            bits <= '0;
        end else if (we) begin
            bits[waddr] <= wdata;
        end
    end

    // Present the addressed bit to the reader.
    always_comb begin
        rdata = bits[raddr];
    end
endmodule

// File: rtl/es_rd_ctrl.sv
// Read-side controller: walks the read pointer, decides frame slips at frame
// starts, executes recenter commands, and registers the serial outputs.
// Assumes: commands are synchronous to the read clock; wsync is the write
// pointer already brought into this domain.
module es_rd_ctrl
    import es_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int AW         = 9,
    parameter int PW         = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] wsync,
    input  logic          en,
    input  logic          cmd_reset,
    input  logic          cmd_align,
    output logic [AW-1:0] raddr,
    input  logic          rdata,
    output logic          r_data,
    output logic          r_fsync,
    output logic          slip_evt,
    output logic          slip_dir
);
    localparam int FW = $clog2(FRAME_BITS);
    localparam logic [PW-1:0]        STEP_FRAME = PW'(FRAME_BITS);
    localparam logic [PW-1:0]        STEP_HALF  = PW'(FRAME_BITS / 2);
    localparam logic signed [PW-1:0] SEP_HALF   = PW'(FRAME_BITS / 2);
    localparam logic signed [PW-1:0] SEP_ONE    = PW'(FRAME_BITS);
    localparam logic signed [PW-1:0] SEP_TWO    = PW'(2 * FRAME_BITS);

    logic [PW-1:0]        rptr;
    logic [PW-1:0]        eff;
    logic signed [PW-1:0] sep;
    logic                 at_start;
    es_slip_e             kind;

    // Separation and slip choice for a read at the current pointer.
    always_comb begin
        sep      = wsync - rptr;
        at_start = (rptr[FW-1:0] == '0);
        kind     = SLIP_NONE;
        if (at_start && (sep < SEP_ONE)) begin
            kind = SLIP_REPEAT;
        end else if (at_start && (sep > SEP_TWO)) begin
            kind = SLIP_DELETE;
        end
        case (kind)
            SLIP_REPEAT: eff = rptr - STEP_FRAME;
            SLIP_DELETE: eff = rptr + STEP_FRAME;
            default:     eff = rptr;
        endcase
        raddr = eff[AW-1:0];
    end

    // Pointer update, commands first, then a read with its slip decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr     <= '0 - STEP_FRAME;
            r_data   <= 1'b0;
            r_fsync  <= 1'b0;
            slip_evt <= 1'b0;
            slip_dir <= 1'b0;
        end else if (cmd_reset) begin
            rptr     <= wsync - STEP_FRAME;
            r_fsync  <= 1'b0;
            slip_evt <= 1'b0;
            slip_dir <= 1'b0;
        end else if (cmd_align) begin
            if (sep < SEP_HALF) begin
                rptr <= wsync - STEP_HALF;
            end
            r_fsync  <= 1'b0;
            slip_evt <= 1'b0;
            slip_dir <= 1'b0;
        end else if (en) begin
            rptr     <= eff + 1'b1;
            r_data   <= rdata;
            r_fsync  <= (eff[FW-1:0] == '0);
            slip_evt <= (kind != SLIP_NONE);
            slip_dir <= (kind == SLIP_DELETE);
        end else begin
            r_fsync  <= 1'b0;
            slip_evt <= 1'b0;
            slip_dir <= 1'b0;
        end
    end

    AST_SLIP_AT_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
        slip_evt |-> r_fsync); // R7
    AST_DIR_ONLY_WITH_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
        slip_dir |-> slip_evt); // R6
    AST_RESET_ONE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> (rptr == $past(wsync) - STEP_FRAME)); // R8
    AST_ALIGN_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_reset && cmd_align && (sep >= SEP_HALF)) |=> $stable(rptr)); // R9
    AST_MID_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_reset && !cmd_align && en && !at_start) |=> (rptr == $past(rptr) + 1'b1)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_reset && !cmd_align && !en) |=> ($stable(r_data) && !slip_evt)); // R1
endmodule

// File: rtl/elastic_store_2f.sv
// Two-frame elastic store with controlled whole-frame slips and host
// recentering. Writes on the line clock, reads on an unrelated backplane clock.
// Assumes: FRAMES is two; each clock domain has its own synchronous reset,
// and both resets are asserted together at power-on.
module elastic_store_2f #(
    parameter int FRAME_BITS = 256,
    parameter int FRAMES     = 2
) (
    input  logic w_clk,
    input  logic w_rst_n,
    input  logic w_en,
    input  logic w_data,
    input  logic w_fsync,
    input  logic r_clk,
    input  logic r_rst_n,
    input  logic r_en,
    input  logic cmd_reset,
    input  logic cmd_align,
    output logic r_data,
    output logic r_fsync,
    output logic slip_evt,
    output logic slip_dir
);
    localparam int DEPTH = FRAME_BITS * FRAMES;
    localparam int AW    = $clog2(DEPTH);
    localparam int PW    = AW + 2;

    logic          we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic          rdata;
    logic [PW-1:0] wgray;
    logic [PW-1:0] wsync;

    es_wr_ptr #(.FRAME_BITS(FRAME_BITS), .AW(AW), .PW(PW)) u_wr (
        .clk   (w_clk),
        .rst_n (w_rst_n),
        .en    (w_en),
        .fsync (w_fsync),
        .we    (we),
        .waddr (waddr),
        .gray  (wgray)
    );

    es_gray_sync #(.W(PW)) u_sync (
        .clk     (r_clk),
        .rst_n   (r_rst_n),
        .gray_in (wgray),
        .bin_out (wsync)
    );

    es_bit_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
        .wclk    (w_clk),
        .w_rst_n (w_rst_n),
        .we      (we),
        .waddr   (waddr),
        .wdata   (w_data),
        .raddr   (raddr),
        .rdata   (rdata)
    );

    es_rd_ctrl #(.FRAME_BITS(FRAME_BITS), .AW(AW), .PW(PW)) u_rd (
        .clk       (r_clk),
        .rst_n     (r_rst_n),
        .wsync     (wsync),
        .en        (r_en),
        .cmd_reset (cmd_reset),
        .cmd_align (cmd_align),
        .raddr     (raddr),
        .rdata     (rdata),
        .r_data    (r_data),
        .r_fsync   (r_fsync),
        .slip_evt  (slip_evt),
        .slip_dir  (slip_dir)
    );
endmodule

// File: tb/elastic_store_2f_test.sv
// Bench: behavioural model of the store, compared on every read clock.
module elastic_store_2f_test;
    localparam int R_PERIOD = 12;
    localparam int W_HALF   = 5;
    localparam int FB       = 256;
    localparam int DEPTH    = 512;
    localparam int PMOD     = 2048;

    logic w_clk = 1'b0, r_clk = 1'b0;
    logic w_rst_n = 1'b0, r_rst_n = 1'b0;
    logic w_en = 1'b0, w_data = 1'b0, w_fsync = 1'b0;
    logic r_en = 1'b0, cmd_reset = 1'b0, cmd_align = 1'b0;
    logic r_data, r_fsync, slip_evt, slip_dir;

    elastic_store_2f uut (
        .w_clk(w_clk), .w_rst_n(w_rst_n), .w_en(w_en), .w_data(w_data),
        .w_fsync(w_fsync), .r_clk(r_clk), .r_rst_n(r_rst_n), .r_en(r_en),
        .cmd_reset(cmd_reset), .cmd_align(cmd_align), .r_data(r_data),
        .r_fsync(r_fsync), .slip_evt(slip_evt), .slip_dir(slip_dir)
    );

    // write edges fall on odd times, read edges on even times: never together
    initial forever #(W_HALF) w_clk = ~w_clk;
    initial begin
        #2;
        forever begin
            r_clk = 1'b1; #(R_PERIOD/2);
            r_clk = 1'b0; #(R_PERIOD/2);
        end
    end

    int n_vec = 0, n_bad = 0;
    int m_wptr = 0, m_rptr = PMOD - FB, m_s1 = 0, m_s2 = 0;
    bit m_mem [0:DEPTH-1];
    bit e_data = 0, e_fs = 0, e_evt = 0, e_dir = 0;
    int n_rep = 0, n_del = 0, n_aeff = 0, n_aign = 0, n_rst = 0, n_snap = 0;
    int w_mode = 0;   // 0 idle, 1 every cycle, 2 half rate
    bit checking = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // write-side model (R2)
    always @(posedge w_clk) begin
        if (!w_rst_n) begin
            m_wptr = 0;
            for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
        end else if (w_en) begin
            int a;
            a = m_wptr;
            if (w_fsync && (a % FB) != 0) begin
                a = ((a / FB + 1) * FB) % PMOD;
                n_snap++;
            end
            m_mem[a % DEPTH] = w_data;
            m_wptr = (a + 1) % PMOD;
        end
    end

    // read-side model: slips R5/R6, commands R8/R9, sync delay R10
    always @(posedge r_clk) begin
        if (!r_rst_n) begin
            m_rptr = PMOD - FB; m_s1 = 0; m_s2 = 0;
            e_data = 0; e_fs = 0; e_evt = 0; e_dir = 0;
        end else begin
            int sep;
            sep = (m_s2 - m_rptr + 2 * PMOD) % PMOD;
            if (sep >= PMOD / 2) sep = sep - PMOD;
            e_evt = 0; e_dir = 0; e_fs = 0;
            if (cmd_reset) begin
                m_rptr = (m_s2 - FB + PMOD) % PMOD;
                n_rst++;
            end else if (cmd_align) begin
                if (sep < FB / 2) begin
                    m_rptr = (m_s2 - FB / 2 + PMOD) % PMOD;
                    n_aeff++;
                end else n_aign++;
            end else if (r_en) begin
                int ea;
                ea = m_rptr;
                if (ea % FB == 0) begin
                    if (sep < FB) begin
                        ea = (ea - FB + PMOD) % PMOD; e_evt = 1; e_dir = 0; n_rep++;
                    end else if (sep > 2 * FB) begin
                        ea = (ea + FB) % PMOD; e_evt = 1; e_dir = 1; n_del++;
                    end
                end
                e_data = m_mem[ea % DEPTH];
                e_fs = (ea % FB == 0);
                m_rptr = (ea + 1) % PMOD;
            end
            m_s2 = m_s1;
            m_s1 = m_wptr;
        end
    end

    // compare away from the read edge
    initial forever begin
        @(negedge r_clk);
        if (checking) begin
            chk(r_data === e_data, "R1 r_data", int'(r_data), int'(e_data));
            chk(r_fsync === e_fs, "R3 r_fsync", int'(r_fsync), int'(e_fs));
            chk(slip_evt === e_evt, "R5/R7 slip_evt", int'(slip_evt), int'(e_evt));
            chk(slip_dir === e_dir, "R6 slip_dir", int'(slip_dir), int'(e_dir));
        end
    end

    // write stimulus
    initial forever begin
        @(negedge w_clk);
        w_data = 1'($urandom);
        w_fsync = ($urandom % 300 == 0);
        case (w_mode)
            1: w_en = 1'b1;
            2: w_en = 1'($urandom);
            default: w_en = 1'b0;
        endcase
    end

    task automatic rcyc(input int n, input int duty);
        for (int i = 0; i < n; i++) begin
            @(negedge r_clk);
            cmd_reset = 1'b0; cmd_align = 1'b0;
            r_en = (($urandom % 100) < duty);
        end
    endtask

    task automatic cmd(input bit rst, input bit aln);
        @(negedge r_clk);
        r_en = 1'b1; cmd_reset = rst; cmd_align = aln;
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(R_PERIOD * 150000);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        repeat (4) @(negedge r_clk);
        // R4: outputs cleared while in reset
        chk(r_data === 1'b0 && r_fsync === 1'b0, "R4 reset data/fsync", int'(r_data), 0);
        chk(slip_evt === 1'b0 && slip_dir === 1'b0, "R4 reset slip", int'(slip_evt), 0);
        w_rst_n = 1'b1; r_rst_n = 1'b1;
        checking = 1;
        // R1/R6: writer faster than reader, deletes follow
        w_mode = 1;
        rcyc(4000, 100);
        // R5: writer at half rate, repeats follow
        w_mode = 2;
        rcyc(3000, 100);
        // R7 with gapped reads and a steady writer
        w_mode = 1;
        rcyc(2000, 60);
        // R8/R9: recentering with a stopped writer
        for (int k = 0; k < 24; k++) begin
            w_mode = 0;
            rcyc(4, 0);
            cmd(1'b1, (k % 3) == 0);   // reset wins over align
            cmd(1'b0, 1'b1);           // separation 256: align ignored
            rcyc(100 + k * 7, 100);
            cmd(1'b0, 1'b1);
            w_mode = 1;
            rcyc(300, 100);
        end
        w_mode = 2;
        rcyc(500, 100);
        checking = 0;
        chk(n_rep > 0, "R5 repeat slip seen", n_rep, 1);
        chk(n_del > 0, "R6 delete slip seen", n_del, 1);
        chk(n_rst > 0, "R8 recenter issued", n_rst, 1);
        chk(n_aeff > 0, "R9 align took effect", n_aeff, 1);
        chk(n_aign > 0, "R9 align ignored", n_aign, 1);
        chk(n_snap > 0, "R2 marker snapped to frame", n_snap, 1);
        summary();
    end
endmodule